// File: doc/BRIEF.md
# Banked Data Address Mapper

This block turns the 8-bit direct file-address field of an instruction into a 12-bit data-memory address. The data space is 4 KB, divided into 16 banks of 256 bytes each, with bank n covering n00h to nFFh. A one-bit access selector chooses how the field is interpreted. When it is 1, the field is an offset inside the bank held in a bank select register. When it is 0, the field addresses a fixed access window instead. Field values 00h to 7Fh reach the first 128 bytes of RAM. Field values 80h to FFh reach the special-function register region at F80h to FFFh, at the top of bank 15.

The bank select register is 8 bits wide. A load strobe with a literal writes it, and it resets to zero. Only its low four bits take part in the mapping. The upper four bits discard whatever is written to them and always read as zero. The address path is combinational from the current field and selector. A load of the bank register changes the mapping from the next cycle on, never in the cycle of the load itself. The register contents are brought out so that the current bank can be read.

Top module: `bank_addr_map`

## Requirements
- R1: While reset is asserted, and after its release until the first load, the bank register output `bank_q` reads 00h.
- R2: When `bank_load` is 1 at a rising clock edge, `bank_q` holds {4'h0, `bank_lit[3:0]`} after that edge.
- R3: Bits 7 to 4 of `bank_q` always read 0, whatever value `bank_lit[7:4]` carries during a load.
- R4: With `acc_sel` = 1, `phys_addr` equals {`bank_q[3:0]`, `fld_addr`}, so bank n maps to n00h to nFFh.
- R5: With `acc_sel` = 0 and `fld_addr` in 00h to 7Fh, `phys_addr` equals 000h to 07Fh ({4'h0, `fld_addr`}), independent of the bank register.
- R6: With `acc_sel` = 0 and `fld_addr` in 80h to FFh, `phys_addr` equals F80h to FFFh ({4'hF, `fld_addr`}), independent of the bank register.
- R7: When `bank_load` is 0 at a rising edge, `bank_q` keeps its value.
- R8: In the cycle in which `bank_load` is 1, `phys_addr` is still formed from the old bank. The new bank applies from the following cycle.
- R9: `phys_addr` follows changes of `fld_addr` and `acc_sel` within the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_load | input | 1 | Strobe that writes the bank register |
| bank_lit | input | 8 | Literal written on a load |
| acc_sel | input | 1 | 1 = banked access, 0 = fixed access window |
| fld_addr | input | 8 | Direct address field of the instruction |
| phys_addr | output | 12 | Resulting data-memory address |
| bank_q | output | 8 | Current bank register value, upper four bits zero |

## Verification
The checker verifies on every cycle that the upper register bits are zero and that a load or a hold lands in the register as required. It also checks that each of the three address cases forms its address from the current register and field. Some behaviours can only be shown by the bench's scenarios. These are the reset value, the use of the old bank during a load cycle, and the window boundary at 7Fh/80h under several banks. Another is that the access window ignores a non-zero bank. The bench shows these by sampling the address inside load cycles and after each bank change.

// File: rtl/bam_pkg.sv
package bam_pkg;
  localparam int unsigned FLD_W   = 8;
  localparam int unsigned BANK_W  = 4;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned ADDR_W  = FLD_W + BANK_W;
  localparam int unsigned LOW_WIN = 128;
  localparam logic [BANK_W-1:0] TOP_BANK = {BANK_W{1'b1}};
  localparam logic [BANK_W-1:0] BOT_BANK = {BANK_W{1'b0}};

  typedef enum logic {
    ACC_WINDOW = 1'b0,
    ACC_BANKED = 1'b1
  } acc_mode_e;
endpackage

// File: rtl/bam_rst_sync.sv
module bam_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bam_bank_reg.sv
module bam_bank_reg #(
  parameter int unsigned BANK_W = 4,
  parameter int unsigned REG_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [REG_W-1:0] load_val,
  output logic [REG_W-1:0] reg_q
);
  localparam int unsigned PAD_W = REG_W - BANK_W;

  logic [BANK_W-1:0] bank_d;
  logic [BANK_W-1:0] bank_r;

  // next-state: clock enable written out
  always_comb begin
    bank_d = bank_r;
    if (load_en) bank_d = load_val[BANK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_r <= '0;
    else        bank_r <= bank_d;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign reg_q = {{PAD_W{1'b0}}, bank_r};
    end else begin : g_nopad
      assign reg_q = bank_r;
    end
  endgenerate
endmodule

// File: rtl/bam_map.sv
module bam_map
  import bam_pkg::*;
#(
  parameter int unsigned F_W    = FLD_W,
  parameter int unsigned B_W    = BANK_W,
  parameter int unsigned LOWWIN = LOW_WIN
) (
  input  logic           acc_sel,
  input  logic [F_W-1:0] fld,
  input  logic [B_W-1:0] bank,
  output logic [F_W+B_W-1:0] addr
);
  localparam logic [F_W-1:0] SPLIT = F_W'(LOWWIN);

  logic [B_W-1:0] win_bank;
  logic [B_W-1:0] sel_bank;

  always_comb begin
    win_bank = (fld < SPLIT) ? B_W'(0) : {B_W{1'b1}};
    sel_bank = (acc_mode_e'(acc_sel) == ACC_BANKED) ? bank : win_bank;
    addr     = {sel_bank, fld};
  end
endmodule

// File: rtl/bank_addr_map.sv
module bank_addr_map
  import bam_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_load,
  input  logic [REG_W-1:0]  bank_lit,
  input  logic              acc_sel,
  input  logic [FLD_W-1:0]  fld_addr,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [REG_W-1:0]  bank_q
);
  logic rst_sync_n;

  bam_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  bam_bank_reg #(.BANK_W(BANK_W), .REG_W(REG_W)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .load_en(bank_load),
    .load_val(bank_lit), .reg_q(bank_q)
  );

  bam_map #(.F_W(FLD_W), .B_W(BANK_W), .LOWWIN(LOW_WIN)) u_map (
    .acc_sel(acc_sel), .fld(fld_addr), .bank(bank_q[BANK_W-1:0]),
    .addr(phys_addr)
  );
endmodule

// File: rtl/bank_addr_map_chk.sv
module bank_addr_map_chk
  import bam_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              bank_load,
  input logic [REG_W-1:0]  bank_lit,
  input logic              acc_sel,
  input logic [FLD_W-1:0]  fld_addr,
  input logic [ADDR_W-1:0] phys_addr,
  input logic [REG_W-1:0]  bank_q
);
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bank_q[REG_W-1:BANK_W] == '0); // R3
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bank_load |=> bank_q[BANK_W-1:0] == $past(bank_lit[BANK_W-1:0])); // R2
  AST_HOLD_BANK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bank_load |=> $stable(bank_q)); // R7
  AST_BANKED_ADDR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_sel |-> phys_addr == {bank_q[BANK_W-1:0], fld_addr}); // R4
  AST_LOW_WINDOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!acc_sel && !fld_addr[FLD_W-1]) |-> phys_addr == {BOT_BANK, fld_addr}); // R5
  AST_SFR_WINDOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!acc_sel && fld_addr[FLD_W-1]) |-> phys_addr == {TOP_BANK, fld_addr}); // R6
endmodule

bind bank_addr_map bank_addr_map_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .bank_load(bank_load),
  .bank_lit(bank_lit), .acc_sel(acc_sel), .fld_addr(fld_addr),
  .phys_addr(phys_addr), .bank_q(bank_q)
);

// File: tb/bank_addr_map_tb.sv
module bank_addr_map_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bank_load;
  logic [7:0]  bank_lit;
  logic        acc_sel;
  logic [7:0]  fld_addr;
  logic [11:0] phys_addr;
  logic [7:0]  bank_q;

  int total = 0;
  int bad   = 0;
  logic [3:0] mdl_bank;

  typedef struct { logic [11:0] exp; string tag; } item_t;
  item_t sb_q[$];
  event  sample_ev;
  bit    done = 1'b0;

  always #5 clk = ~clk;

  bank_addr_map u_dut (
    .clk(clk), .rst_n(rst_n), .bank_load(bank_load), .bank_lit(bank_lit),
    .acc_sel(acc_sel), .fld_addr(fld_addr), .phys_addr(phys_addr),
    .bank_q(bank_q)
  );

  function automatic logic [11:0] ref_addr(logic a, logic [7:0] f, logic [3:0] b);
    if (a)           return {b, f};
    else if (f < 8'h80) return {4'h0, f};
    else             return {4'hF, f};
  endfunction

  // monitor: pops expected items and compares with the design
  always @(sample_ev) begin
    item_t it;
    it = sb_q.pop_front();
    total++;
    if (phys_addr !== it.exp) begin
      bad++;
      $display("FAIL %s phys_addr act=%03h exp=%03h", it.tag, phys_addr, it.exp);
    end
  end

  task automatic check_bank(logic [7:0] exp, string tag);
    total++;
    if (bank_q !== exp) begin
      bad++;
      $display("FAIL %s bank_q act=%02h exp=%02h", tag, bank_q, exp);
    end
  endtask

  // driver: sets inputs, pushes expected, triggers monitor (no clock edge needed, R9)
  task automatic drive(logic a, logic [7:0] f, string tag);
    item_t it;
    acc_sel  = a;
    fld_addr = f;
    it.exp = ref_addr(a, f, mdl_bank);
    it.tag = tag;
    sb_q.push_back(it);
    #1; ->sample_ev; #0;
  endtask

  task automatic load_bank(logic [7:0] lit, string tag);
    @(negedge clk);
    bank_load = 1'b1;
    bank_lit  = lit;
    drive(1'b1, 8'h44, "R8");          // still old bank in load cycle
    @(posedge clk); #1;
    mdl_bank  = lit[3:0];
    bank_load = 1'b0;
    bank_lit  = 8'h00;
    check_bank({4'h0, lit[3:0]}, tag); // R2, R3
    drive(1'b1, 8'h44, "R8");          // new bank next cycle
  endtask

  initial begin
    rst_n = 1'b0; bank_load = 1'b0; bank_lit = 8'h00;
    acc_sel = 1'b1; fld_addr = 8'h00; mdl_bank = 4'h0;
    repeat (3) @(negedge clk);
    check_bank(8'h00, "R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_bank(8'h00, "R1");
    drive(1'b1, 8'h00, "R4");
    drive(1'b1, 8'hFF, "R4");
    drive(1'b0, 8'h00, "R5");
    drive(1'b0, 8'h7F, "R5");
    drive(1'b0, 8'h80, "R6");
    drive(1'b0, 8'hFF, "R6");
    load_bank(8'h03, "R2");
    drive(1'b1, 8'h40, "R4");
    drive(1'b1, 8'h45, "R9");
    drive(1'b0, 8'h40, "R5");
    drive(1'b0, 8'hE8, "R6");
    load_bank(8'hA5, "R3");
    check_bank(8'h05, "R3");
    repeat (3) @(negedge clk);
    check_bank(8'h05, "R7");
    drive(1'b1, 8'hC0, "R4");
    load_bank(8'hFF, "R2");
    drive(1'b1, 8'h80, "R4");
    drive(1'b0, 8'h7F, "R5");
    drive(1'b0, 8'h80, "R6");
    drive(1'b1, 8'h7F, "R9");
    load_bank(8'h60, "R3");
    drive(1'b1, 8'h12, "R4");
    drive(1'b0, 8'h12, "R5");
    @(negedge clk);
    bank_lit = 8'h0E;                  // literal without strobe
    @(negedge clk);
    check_bank(8'h00, "R7");
    bank_lit = 8'h00;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    #2;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule